// File: doc/BRIEF.md
# Programmable Permission Indirection Lookup

This block turns a 4-bit permission index, delivered by a translation walk, into the base permissions for an unprivileged access. It does not take the permissions from page-table bits. Software programs a 64-bit register that holds sixteen 4-bit codes. The index selects one code, and a fixed decoder expands that code into six flags: read, write, execute, shadow-stack read, shadow-stack write, and whether the later overlay stage applies. Codes that are reserved collapse to no access. Their overlay flag depends on the half of the code space they sit in.

A write port replaces the whole register in one cycle. A global enable chooses between the table and a bypass. When the enable is low, the table is not consulted. The result is still marked valid, but every permission is clear and a bypass flag is raised, so the caller uses its direct permission path instead.

The result is registered. A small result state machine has three states: `ST_IDLE` (no result), `ST_LOOKUP` (decoded table result) and `ST_BYPASS` (indirection disabled). Every cycle it takes one of three transitions. A request with the enable high goes to `ST_LOOKUP`. A request with the enable low goes to `ST_BYPASS`. No request goes to `ST_IDLE`. Any state can reach any of the three.

Top module: `pie_lookup`

## Requirements
- R1: Index m selects register bits [4m+3:4m]. Index 0 is bits [3:0] and index 15 is bits [63:60].
- R2: Every code in 0000..0111 sets the overlay flag, and every code in 1000..1111 clears it.
- R3: Codes with the overlay set decode as follows:
  - 0000: nothing.
  - 0001: read.
  - 0010: execute.
  - 0011: read and execute.
  - 0101: read and write.
  - 0110 and 0111: read, write and execute.
  - Write is never granted without read.
- R4: Code 0100 decodes to no permission, with the overlay flag set.
- R5: Codes with the overlay clear decode as follows:
  - 1000: read.
  - 1010: read and execute.
  - 1100: read and write.
  - 1110: read, write and execute.
  - 1001: read, shadow-stack read and shadow-stack write, with no write and no execute.
- R6: Codes 1011, 1101 and 1111 decode to no permission, with the overlay flag clear.
- R7: A request presented in cycle N gives `res_valid` high in cycle N+1. A cycle without a request gives `res_valid` low in the next cycle, with every result flag low.
- R8: A request made while `ind_en` is low gives a valid result in the next cycle. That result has `res_bypass` high and all six permission and overlay flags low, whatever the register holds. A request made while `ind_en` is high leaves `res_bypass` low.
- R9: A lookup in the same cycle as a register write decodes the old register contents. Lookups from the next cycle on see the new contents.
- R10: After reset the register is all zeros, so every index decodes to no access with the overlay flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | New register contents: sixteen 4-bit codes |
| lk_req | input | 1 | Lookup request |
| lk_index | input | 4 | Permission index from the walk |
| ind_en | input | 1 | Indirection enable; low selects the bypass |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_read | output | 1 | Read granted |
| res_write | output | 1 | Write granted |
| res_exec | output | 1 | Execute granted |
| res_ss_read | output | 1 | Shadow-stack read granted |
| res_ss_write | output | 1 | Shadow-stack write granted |
| res_overlay | output | 1 | Overlay stage applies |
| res_bypass | output | 1 | Indirection disabled; use the direct permission path |

## Verification
The assertions assume that `ind_en` and `lk_req` are sampled on the same edge as the result register. They also assume that every 4-bit index is legal, so they impose no rule on the index. The stimulus changes all inputs only on the falling edge. It draws random indices over the full 0..15 range and random register images, so every code can reach every slot. Directed phases add to this: reset, a write in the same cycle as a lookup, and bypass against a non-zero table.

// File: rtl/pie_pkg.sv
package pie_pkg;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
        logic ss_rd;
        logic ss_wr;
        logic ovl;
    } perm_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_BYPASS = 2'd2
    } res_state_e;

    localparam perm_t PERM_NONE = '0;

endpackage

// File: rtl/pie_table.sv
module pie_table #(
    parameter int ENTRIES = 16,
    parameter int CODE_W  = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int REG_W  = ENTRIES * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CODE_W-1:0] rd_code
);

    logic [REG_W-1:0] flat;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic [CODE_W-1:0] slot_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en) begin
                slot_q <= wr_data[g*CODE_W +: CODE_W];
            end
        end

        assign flat[g*CODE_W +: CODE_W] = slot_q;
    end

    // The read sees the stored value, which is the old one during a write cycle.
    always_comb begin
        rd_code = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_code = flat[i*CODE_W +: CODE_W];
            end
        end
    end

endmodule

// File: rtl/pie_decode.sv
module pie_decode
    import pie_pkg::*;
(
    input  logic [3:0] code,
    output perm_t      perm
);

    always_comb begin
        perm = PERM_NONE;
        unique case (code)
            4'b0000: perm = '{rd:1'b0, wr:1'b0, ex:1'b0, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b1};
            4'b0001: perm = '{rd:1'b1, wr:1'b0, ex:1'b0, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b1};
            4'b0010: perm = '{rd:1'b0, wr:1'b0, ex:1'b1, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b1};
            4'b0011: perm = '{rd:1'b1, wr:1'b0, ex:1'b1, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b1};
            4'b0100: perm = '{rd:1'b0, wr:1'b0, ex:1'b0, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b1};
            4'b0101: perm = '{rd:1'b1, wr:1'b1, ex:1'b0, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b1};
            4'b0110: perm = '{rd:1'b1, wr:1'b1, ex:1'b1, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b1};
            4'b0111: perm = '{rd:1'b1, wr:1'b1, ex:1'b1, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b1};
            4'b1000: perm = '{rd:1'b1, wr:1'b0, ex:1'b0, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b0};
            4'b1001: perm = '{rd:1'b1, wr:1'b0, ex:1'b0, ss_rd:1'b1, ss_wr:1'b1, ovl:1'b0};
            4'b1010: perm = '{rd:1'b1, wr:1'b0, ex:1'b1, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b0};
            4'b1011: perm = '{rd:1'b0, wr:1'b0, ex:1'b0, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b0};
            4'b1100: perm = '{rd:1'b1, wr:1'b1, ex:1'b0, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b0};
            4'b1101: perm = '{rd:1'b0, wr:1'b0, ex:1'b0, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b0};
            4'b1110: perm = '{rd:1'b1, wr:1'b1, ex:1'b1, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b0};
            4'b1111: perm = '{rd:1'b0, wr:1'b0, ex:1'b0, ss_rd:1'b0, ss_wr:1'b0, ovl:1'b0};
            default: perm = PERM_NONE;
        endcase
    end

endmodule

// File: rtl/pie_lookup.sv
module pie_lookup
    import pie_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int CODE_W  = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int REG_W  = ENTRIES * CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             lk_req,
    input  logic [IDX_W-1:0] lk_index,
    input  logic             ind_en,
    output logic             res_valid,
    output logic             res_read,
    output logic             res_write,
    output logic             res_exec,
    output logic             res_ss_read,
    output logic             res_ss_write,
    output logic             res_overlay,
    output logic             res_bypass
);

    logic [CODE_W-1:0] code_sel;
    perm_t             perm_d;
    perm_t             perm_q;
    res_state_e        state_q;
    res_state_e        state_d;

    pie_table #(
        .ENTRIES (ENTRIES),
        .CODE_W  (CODE_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_idx  (lk_index),
        .rd_code (code_sel)
    );

    pie_decode u_decode (
        .code (code_sel),
        .perm (perm_d)
    );

    // Next-state selection for the result stage.
    always_comb begin
        if (!lk_req) begin
            state_d = ST_IDLE;
        end else if (ind_en) begin
            state_d = ST_LOOKUP;
        end else begin
            state_d = ST_BYPASS;
        end
    end

    // State register and captured permissions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            perm_q  <= PERM_NONE;
        end else begin
            state_q <= state_d;
            perm_q  <= (state_d == ST_LOOKUP) ? perm_d : PERM_NONE;
        end
    end

    // Output decode from the result state.
    always_comb begin
        res_valid    = 1'b0;
        res_bypass   = 1'b0;
        res_read     = 1'b0;
        res_write    = 1'b0;
        res_exec     = 1'b0;
        res_ss_read  = 1'b0;
        res_ss_write = 1'b0;
        res_overlay  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_LOOKUP: begin
                res_valid    = 1'b1;
                res_read     = perm_q.rd;
                res_write    = perm_q.wr;
                res_exec     = perm_q.ex;
                res_ss_read  = perm_q.ss_rd;
                res_ss_write = perm_q.ss_wr;
                res_overlay  = perm_q.ovl;
            end
            ST_BYPASS: begin
                res_valid  = 1'b1;
                res_bypass = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/pie_lookup_chk.sv
module pie_lookup_chk (
    input logic clk,
    input logic rst_n,
    input logic lk_req,
    input logic ind_en,
    input logic res_valid,
    input logic res_read,
    input logic res_write,
    input logic res_exec,
    input logic res_ss_read,
    input logic res_ss_write,
    input logic res_overlay,
    input logic res_bypass
);

    // R7
    req_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> res_valid);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!res_valid && !res_bypass && !res_read && !res_write &&
                     !res_exec && !res_ss_read && !res_ss_write && !res_overlay));

    // R8
    bypass_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !ind_en) |=> (res_bypass && !res_read && !res_write && !res_exec &&
                                 !res_ss_read && !res_ss_write && !res_overlay));

    // R8
    enabled_no_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && ind_en) |=> !res_bypass);

    // R5
    shadow_write_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_ss_write |-> (res_ss_read && res_read && !res_write && !res_exec && !res_overlay));

    // R3
    write_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_write |-> res_read);

endmodule

bind pie_lookup pie_lookup_chk u_chk (.*);

// File: tb/tb_pie_lookup.sv
`timescale 1ns/1ps
module tb_pie_lookup;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        lk_req = 1'b0;
    logic [3:0]  lk_index = '0;
    logic        ind_en = 1'b1;
    logic res_valid, res_read, res_write, res_exec;
    logic res_ss_read, res_ss_write, res_overlay, res_bypass;

    int checks = 0;
    int fails = 0;
    logic [63:0] model = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pie_lookup dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .lk_req(lk_req), .lk_index(lk_index), .ind_en(ind_en),
        .res_valid(res_valid), .res_read(res_read), .res_write(res_write),
        .res_exec(res_exec), .res_ss_read(res_ss_read), .res_ss_write(res_ss_write),
        .res_overlay(res_overlay), .res_bypass(res_bypass)
    );

    // Expected {valid, rd, wr, ex, ss_rd, ss_wr, ovl, bypass} for a decoded code.
    function automatic logic [7:0] exp_code(input logic [3:0] c);
        logic r, w, x, sr, sw, o;
        o  = ~c[3];
        sr = (c == 4'b1001);
        sw = (c == 4'b1001);
        if (c[3]) begin
            r = ~c[0] || (c == 4'b1001);
            w = ~c[0] && c[2];
            x = ~c[0] && c[1];
        end else begin
            r = (c == 4'b0001) || (c == 4'b0011) || (c >= 4'b0101);
            w = (c >= 4'b0101);
            x = (c == 4'b0010) || (c == 4'b0011) || (c >= 4'b0110);
        end
        return {1'b1, r, w, x, sr, sw, o, 1'b0};
    endfunction

    function automatic logic [7:0] actual();
        return {res_valid, res_read, res_write, res_exec,
                res_ss_read, res_ss_write, res_overlay, res_bypass};
    endfunction

    task automatic check(input logic [7:0] exp, input string tag);
        checks++;
        if (actual() !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, actual(), exp);
        end
    endtask

    // One cycle: drive at the falling edge, check the result one falling edge later.
    task automatic step(input logic req, input logic [3:0] idx, input logic en,
                        input logic we, input logic [63:0] wd, input string tag);
        logic [7:0] exp;
        lk_req = req; lk_index = idx; ind_en = en; wr_en = we; wr_data = wd;
        if (!req)      exp = 8'h00;
        else if (!en)  exp = 8'b1000_0001;
        else           exp = exp_code(model[idx*4 +: 4]);
        @(posedge clk);
        if (we) model = wd;
        @(negedge clk);
        lk_req = 1'b0; wr_en = 1'b0;
        check(exp, tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] img;
        void'($urandom(32'd7391));
        repeat (3) @(negedge clk);
        check(8'h00, "R7 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        // R10: every index decodes to no access with overlay set after reset.
        for (int i = 0; i < 16; i++) step(1'b1, 4'(i), 1'b1, 1'b0, '0, "R10");

        // R1..R6: slot m holds code m; each index exposes its own code.
        for (int m = 0; m < 16; m++) img[m*4 +: 4] = 4'(m);
        step(1'b0, 4'd0, 1'b1, 1'b1, img, "R7 idle");
        for (int i = 0; i < 16; i++) step(1'b1, 4'(i), 1'b1, 1'b0, '0, "R1 R2 R3 R4 R5 R6");

        // R1: reversed layout, index 0 must read bits [3:0] = code 15.
        for (int m = 0; m < 16; m++) img[m*4 +: 4] = 4'(15 - m);
        step(1'b0, 4'd0, 1'b1, 1'b1, img, "R7 idle");
        step(1'b1, 4'd0, 1'b1, 1'b0, '0, "R1 low slot");
        step(1'b1, 4'd15, 1'b1, 1'b0, '0, "R1 high slot");
        step(1'b1, 4'd6, 1'b1, 1'b0, '0, "R5 shadow code");
        step(1'b1, 4'd11, 1'b1, 1'b0, '0, "R4 reserved low");

        // R9: write and lookup together use the old table, then the new one.
        step(1'b1, 4'd3, 1'b1, 1'b1, {16{4'b1001}}, "R9 old value");
        step(1'b1, 4'd3, 1'b1, 1'b0, '0, "R9 new value");

        // R8: bypass ignores a non-zero table, then lookups resume.
        step(1'b1, 4'd3, 1'b0, 1'b0, '0, "R8 bypass");
        step(1'b1, 4'd9, 1'b0, 1'b0, '0, "R8 bypass");
        step(1'b1, 4'd9, 1'b1, 1'b0, '0, "R8 resume");
        step(1'b0, 4'd9, 1'b0, 1'b0, '0, "R7 no request");

        // Random mix: R1..R9.
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[7:4], r[3:2] != 2'b00, r[11:8] == 4'd0,
                 {$urandom, $urandom}, "R1 R2 R3 R5 R6 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule